// File: doc/BRIEF.md
# Scalar Binary64 Adder with Vector Lane Merge

This block adds the lowest IEEE-754 binary64 element of two vector operands and returns a whole destination vector. Lane 0 carries the rounded sum. The lanes above it are filled according to one of three operand forms:
- **Two-operand form:** the old destination is both the first addend and the source of every upper bit.
- **Three-operand form:** the second 64-bit lane is copied from the first source and everything above 127 is cleared.
- **Predicated form:** behaves like the three-operand form, but lane 0 can be suppressed by a predicate bit. A suppressed lane 0 is either merged with the old destination or zeroed.

The rounding direction is chosen per operation. A per-operation rounding field overrides the global one only when the override is enabled and the second source is a register. Each result comes with five exception flags. A sticky copy of the flags collects the flags of every completed operation since reset.

The datapath is a combinational align/add/normalize/round path followed by one output register, so each accepted operation appears exactly one cycle later. Subnormal inputs are used at full precision; nothing is flushed to zero.

Top module: `fp64_scalar_add`

## Requirements
- R1: `out_valid_o` is `in_valid_i` delayed by exactly one clock. `dest_o` and `flags_o` change only in the cycle after an accepted operation and otherwise hold their values.
- R2: `dest_o[63:0]` is the binary64 sum of the two low operands, rounded by the selected mode. Mode encoding: 00 to nearest-even, 01 toward minus infinity, 10 toward plus infinity, 11 toward zero.
- R3: The mode is `op_rnd_i` when `op_rnd_en_i` and `src2_is_reg_i` are both 1. In every other case it is `glob_rnd_i`.
- R4: Form 00 (two-operand): the first addend is `dest_old_i[63:0]` and the low lane of `src1_i` is ignored. All destination bits above 63 equal `dest_old_i`.
- R5: Forms 01 and 11 (three-operand): destination bits 127:64 equal `src1_i[127:64]` and all bits from 128 upward are 0.
- R6: Form 10 (predicated): lane 0 takes the sum when `pred_use_i` is 0 or `pred_bit_i` is 1. Otherwise lane 0 keeps `dest_old_i[63:0]` when `zero_sel_i` is 0 and becomes 0 when it is 1, and a suppressed lane raises no flags. Bits 127:64 and up behave as in R5 whatever the predicate.
- R7: A signalling NaN operand raises invalid. A NaN result is the quieted NaN of source 1 if source 1 is NaN, and otherwise that of source 2; quieting sets fraction bit 51.
- R8: Infinities of opposite sign give 0xFFF8000000000000 with invalid. An infinity plus a finite value gives that infinity with no flag.
- R9: An exact zero sum of opposite-signed operands is +0, or -0 under mode 01. Two zeros of the same sign keep that sign.
- R10: On overflow the result is infinity (mode 00, or rounding away from zero in the direction of the sign) or the largest finite value of that sign otherwise, with overflow and inexact set.
- R11: Flag bits: [0] invalid, [1] denormal (either operand subnormal), [2] overflow, [3] underflow (subnormal result that is inexact), [4] inexact (the rounded result differs from the exact sum).
- R12: Reset clears every output. `sticky_flags_o` is the OR of `flags_o` of all operations completed since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid_i | input | 1 | Operation accepted this cycle |
| form_i | input | 2 | Operand form: 00 two-operand, 01 three-operand, 10 predicated, 11 as 01 |
| src1_i | input | MAXVL | First source vector |
| src2_i | input | MAXVL | Second source vector (only bits 63:0 used) |
| dest_old_i | input | MAXVL | Previous destination value |
| pred_use_i | input | 1 | Predicate active in form 10 |
| pred_bit_i | input | 1 | Predicate bit for lane 0 |
| zero_sel_i | input | 1 | 1 zeroes a suppressed lane, 0 merges it |
| op_rnd_en_i | input | 1 | Per-operation rounding override enable |
| op_rnd_i | input | 2 | Per-operation rounding mode |
| src2_is_reg_i | input | 1 | Second source is a register |
| glob_rnd_i | input | 2 | Global rounding mode |
| out_valid_o | output | 1 | Result valid |
| dest_o | output | MAXVL | Destination vector |
| flags_o | output | 5 | Exception flags of the last result |
| sticky_flags_o | output | 5 | Accumulated flags since reset |

## Verification
The bench builds the block at its default width of 256 bits. At that width lanes 2 and 3 exist, so clearing above bit 127 (three-operand and predicated forms) and preserving those bits (two-operand form) are both visible at the ports. Random operands with clustered exponents drive deep cancellation, wide alignment shifts and subnormal inputs through all four rounding modes. The reference computes the exact rounding error of the host addition and steps the result by one unit to get the directed modes.

// File: rtl/fp64_add_pkg.sv
package fp64_add_pkg;

  localparam int FP_W   = 64;
  localparam int FLG_W  = 5;
  localparam int FLG_INV = 0;
  localparam int FLG_DEN = 1;
  localparam int FLG_OVF = 2;
  localparam int FLG_UNF = 3;
  localparam int FLG_INX = 4;

  localparam logic [FP_W-1:0] DEFAULT_QNAN = 64'hFFF8_0000_0000_0000;
  localparam logic [FP_W-1:0] QUIET_BIT    = 64'h0008_0000_0000_0000;

  typedef enum logic [1:0] {
    FORM_TWO_OP = 2'b00,
    FORM_THREE  = 2'b01,
    FORM_PRED   = 2'b10,
    FORM_THREE2 = 2'b11
  } form_e;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_DOWN = 2'b01,
    RM_UP   = 2'b10,
    RM_ZERO = 2'b11
  } rmode_e;

  typedef logic [FLG_W-1:0] flags_t;

  function automatic logic [5:0] lead_zeros56(input logic [55:0] v);
    logic [5:0] n;
    logic       found;
    n = 6'd56;
    found = 1'b0;
    for (int i = 55; i >= 0; i--) begin
      if (!found && v[i]) begin
        n = 6'(55 - i);
        found = 1'b1;
      end
    end
    return n;
  endfunction

endpackage

// File: rtl/fp64_rnd_select.sv
module fp64_rnd_select
  import fp64_add_pkg::*;
(
  input  logic   op_en,
  input  logic   src2_reg,
  input  logic [1:0] op_mode,
  input  logic [1:0] glob_mode,
  output rmode_e mode
);

  always_comb begin
    if (op_en && src2_reg) mode = rmode_e'(op_mode);
    else                   mode = rmode_e'(glob_mode);
  end

endmodule

// File: rtl/fp64_add_core.sv
module fp64_add_core
  import fp64_add_pkg::*;
(
  input  logic [63:0] a,
  input  logic [63:0] b,
  input  rmode_e      rm,
  output logic [63:0] res,
  output flags_t      flg
);

  logic a_nan, b_nan, a_snan, b_snan, a_inf, b_inf, a_sub, b_sub;

  logic        swap, eff_sub, r_sign, up, inx, stk, zsign, to_inf;
  logic [63:0] big, sml, msk, fin_res;
  logic [11:0] e_big, e_sml, diff, lim, e_n, e_r;
  logic [5:0]  dsh, lz, sh;
  logic [52:0] m_big, m_sml, mant;
  logic [55:0] w_sml, al, nrm;
  logic [56:0] sum;
  logic [53:0] rnd;
  flags_t      fin_flg;

  // operand classification
  always_comb begin
    a_nan  = (&a[62:52]) && (|a[51:0]);
    b_nan  = (&b[62:52]) && (|b[51:0]);
    a_snan = a_nan && !a[51];
    b_snan = b_nan && !b[51];
    a_inf  = (&a[62:52]) && !(|a[51:0]);
    b_inf  = (&b[62:52]) && !(|b[51:0]);
    a_sub  = !(|a[62:52]) && (|a[51:0]);
    b_sub  = !(|b[62:52]) && (|b[51:0]);
  end

  // finite path: align, add, normalize, round
  always_comb begin
    swap  = b[62:0] > a[62:0];
    big   = swap ? b : a;
    sml   = swap ? a : b;
    e_big = (big[62:52] == 11'd0) ? 12'd1 : {1'b0, big[62:52]};
    e_sml = (sml[62:52] == 11'd0) ? 12'd1 : {1'b0, sml[62:52]};
    m_big = {|big[62:52], big[51:0]};
    m_sml = {|sml[62:52], sml[51:0]};
    diff  = e_big - e_sml;
    dsh   = (diff > 12'd57) ? 6'd57 : diff[5:0];
    w_sml = {m_sml, 3'b000};
    al    = (dsh >= 6'd56) ? 56'd0 : (w_sml >> dsh);
    msk   = (64'd1 << dsh) - 64'd1;
    stk   = |({8'd0, w_sml} & msk);
    eff_sub = big[63] ^ sml[63];
    r_sign  = big[63];
    if (eff_sub) sum = {1'b0, m_big, 3'b000} - {1'b0, al[55:1], al[0] | stk};
    else         sum = {1'b0, m_big, 3'b000} + {1'b0, al[55:1], al[0] | stk};

    lz  = lead_zeros56(sum[55:0]);
    lim = e_big - 12'd1;
    sh  = ({6'd0, lz} < lim) ? lz : lim[5:0];
    if (sum[56]) begin
      nrm = {sum[56:2], sum[1] | sum[0]};
      e_n = e_big + 12'd1;
    end else begin
      nrm = sum[55:0] << sh;
      e_n = e_big - {6'd0, sh};
    end

    inx = |nrm[2:0];
    case (rm)
      RM_NEAR: up = nrm[2] && (nrm[1] || nrm[0] || nrm[3]);
      RM_DOWN: up = inx && r_sign;
      RM_UP:   up = inx && !r_sign;
      default: up = 1'b0;
    endcase
    rnd = {1'b0, nrm[55:3]} + {53'd0, up};
    if (rnd[53]) begin
      mant = rnd[53:1];
      e_r  = e_n + 12'd1;
    end else begin
      mant = rnd[52:0];
      e_r  = e_n;
    end

    zsign  = eff_sub ? (rm == RM_DOWN) : big[63];
    to_inf = (rm == RM_NEAR) || (rm == RM_UP && !r_sign) || (rm == RM_DOWN && r_sign);
    fin_flg = '0;
    if (sum == 57'd0) begin
      fin_res = {zsign, 63'd0};
    end else if (e_r >= 12'd2047) begin
      fin_res = to_inf ? {r_sign, 11'h7FF, 52'd0} : {r_sign, 11'h7FE, {52{1'b1}}};
      fin_flg[FLG_OVF] = 1'b1;
      fin_flg[FLG_INX] = 1'b1;
    end else begin
      fin_res = {r_sign, (mant[52] ? e_r[10:0] : 11'd0), mant[51:0]};
      fin_flg[FLG_INX] = inx;
      fin_flg[FLG_UNF] = !nrm[55] && inx;
    end
  end

  // special operand resolution
  always_comb begin
    flg = '0;
    flg[FLG_DEN] = a_sub | b_sub;
    if (a_nan || b_nan) begin
      flg[FLG_INV] = a_snan | b_snan;
      res = a_nan ? (a | QUIET_BIT) : (b | QUIET_BIT);
    end else if (a_inf && b_inf && (a[63] != b[63])) begin
      flg[FLG_INV] = 1'b1;
      res = DEFAULT_QNAN;
    end else if (a_inf) begin
      res = a;
    end else if (b_inf) begin
      res = b;
    end else begin
      res = fin_res;
      flg = flg | fin_flg;
    end
  end

endmodule

// File: rtl/fp64_lane_merge.sv
module fp64_lane_merge
  import fp64_add_pkg::*;
#(
  parameter int MAXVL = 256
) (
  input  form_e             form,
  input  logic              lane_wr,
  input  logic              zero_sel,
  input  logic [63:0]       sum,
  input  logic [MAXVL-1:0]  src1,
  input  logic [MAXVL-1:0]  dest_old,
  output logic [MAXVL-1:0]  dest
);

  localparam int LANES = MAXVL / 64;

  logic keep_old;
  assign keep_old = (form == FORM_TWO_OP);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    if (g == 0) begin : g_low
      assign dest[63:0] = lane_wr  ? sum :
                          zero_sel ? 64'd0 : dest_old[63:0];
    end else if (g == 1) begin : g_mid
      assign dest[127:64] = keep_old ? dest_old[127:64] : src1[127:64];
    end else begin : g_high
      assign dest[g*64 +: 64] = keep_old ? dest_old[g*64 +: 64] : 64'd0;
    end
  end

endmodule

// File: rtl/fp64_scalar_add.sv
module fp64_scalar_add
  import fp64_add_pkg::*;
#(
  parameter int MAXVL = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid_i,
  input  logic [1:0]       form_i,
  input  logic [MAXVL-1:0] src1_i,
  input  logic [MAXVL-1:0] src2_i,
  input  logic [MAXVL-1:0] dest_old_i,
  input  logic             pred_use_i,
  input  logic             pred_bit_i,
  input  logic             zero_sel_i,
  input  logic             op_rnd_en_i,
  input  logic [1:0]       op_rnd_i,
  input  logic             src2_is_reg_i,
  input  logic [1:0]       glob_rnd_i,
  output logic             out_valid_o,
  output logic [MAXVL-1:0] dest_o,
  output logic [4:0]       flags_o,
  output logic [4:0]       sticky_flags_o
);

  form_e            form;
  rmode_e           rm_sel;
  logic [63:0]      opa, sum;
  flags_t           add_flg, flg_gated;
  logic             lane_wr;
  logic [MAXVL-1:0] dest_nxt;
  logic             unused_hi;

  assign form      = form_e'(form_i);
  assign opa       = (form == FORM_TWO_OP) ? dest_old_i[63:0] : src1_i[63:0];
  assign lane_wr   = (form != FORM_PRED) || !pred_use_i || pred_bit_i;
  assign flg_gated = lane_wr ? add_flg : '0;
  assign unused_hi = ^{src1_i, src2_i[MAXVL-1:64]};

  fp64_rnd_select u_rsel (
    .op_en     (op_rnd_en_i),
    .src2_reg  (src2_is_reg_i),
    .op_mode   (op_rnd_i),
    .glob_mode (glob_rnd_i),
    .mode      (rm_sel)
  );

  fp64_add_core u_core (
    .a   (opa),
    .b   (src2_i[63:0]),
    .rm  (rm_sel),
    .res (sum),
    .flg (add_flg)
  );

  fp64_lane_merge #(.MAXVL(MAXVL)) u_merge (
    .form     (form),
    .lane_wr  (lane_wr),
    .zero_sel (zero_sel_i),
    .sum      (sum),
    .src1     (src1_i),
    .dest_old (dest_old_i),
    .dest     (dest_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid_o    <= 1'b0;
      dest_o         <= '0;
      flags_o        <= '0;
      sticky_flags_o <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) begin
        dest_o         <= dest_nxt;
        flags_o        <= flg_gated;
        sticky_flags_o <= sticky_flags_o | flg_gated;
      end
    end
  end

  a_r1_valid_follow: assert property (@(posedge clk) disable iff (rst)
    in_valid_i |=> out_valid_o);
  a_r1_valid_drop: assert property (@(posedge clk) disable iff (rst)
    !in_valid_i |=> (!out_valid_o && $stable(dest_o)));
  a_r4_two_op_upper: assert property (@(posedge clk) disable iff (rst)
    (in_valid_i && form_i == 2'b00) |=> (dest_o[MAXVL-1:64] == $past(dest_old_i[MAXVL-1:64])));
  a_r5_mid_lane: assert property (@(posedge clk) disable iff (rst)
    (in_valid_i && form_i != 2'b00) |=> (dest_o[127:64] == $past(src1_i[127:64])));
  a_r6_zero_lane: assert property (@(posedge clk) disable iff (rst)
    (in_valid_i && form_i == 2'b10 && pred_use_i && !pred_bit_i && zero_sel_i) |=> (dest_o[63:0] == 64'd0));
  a_r6_quiet_flags: assert property (@(posedge clk) disable iff (rst)
    (in_valid_i && form_i == 2'b10 && pred_use_i && !pred_bit_i) |=> (flags_o == 5'd0));
  a_r10_ovf_inexact: assert property (@(posedge clk) disable iff (rst)
    (out_valid_o && flags_o[FLG_OVF]) |-> flags_o[FLG_INX]);
  a_r12_sticky_keep: assert property (@(posedge clk) disable iff (rst)
    ($past(sticky_flags_o) & ~sticky_flags_o) == 5'd0);

  if (MAXVL > 128) begin : g_hi_chk
    a_r5_high_clear: assert property (@(posedge clk) disable iff (rst)
      (in_valid_i && form_i != 2'b00) |=> (dest_o[MAXVL-1:128] == '0));
  end

endmodule

// File: tb/fp64_scalar_add_test.sv
`timescale 1ns/1ps
module fp64_scalar_add_test;

  localparam int MAXVL = 256;

  logic             clk = 1'b0;
  logic             rst;
  logic             in_valid;
  logic [1:0]       form;
  logic [MAXVL-1:0] src1, src2, dold;
  logic             pu, pb, zs, oen, isreg;
  logic [1:0]       orm, grm;
  logic             out_valid;
  logic [MAXVL-1:0] dest;
  logic [4:0]       flags, sticky;

  always #4 clk = ~clk;

  fp64_scalar_add #(.MAXVL(MAXVL)) uut (
    .clk(clk), .rst(rst), .in_valid_i(in_valid), .form_i(form),
    .src1_i(src1), .src2_i(src2), .dest_old_i(dold),
    .pred_use_i(pu), .pred_bit_i(pb), .zero_sel_i(zs),
    .op_rnd_en_i(oen), .op_rnd_i(orm), .src2_is_reg_i(isreg), .glob_rnd_i(grm),
    .out_valid_o(out_valid), .dest_o(dest), .flags_o(flags), .sticky_flags_o(sticky)
  );

  typedef struct {
    logic [MAXVL-1:0] dv;
    logic [4:0]       fv;
    string            tag;
  } exp_t;

  exp_t             sb_q[$];
  int               n_chk = 0;
  int               n_fail = 0;
  logic [4:0]       sticky_exp = 5'd0;
  logic [MAXVL-1:0] last_dest = '0;
  logic             v_d = 1'b0;

  localparam logic [63:0] ONE  = 64'h3FF0_0000_0000_0000;
  localparam logic [63:0] MONE = 64'hBFF0_0000_0000_0000;
  localparam logic [63:0] TWO  = 64'h4000_0000_0000_0000;
  localparam logic [63:0] H53  = 64'h3CA0_0000_0000_0000;
  localparam logic [63:0] MAXF = 64'h7FEF_FFFF_FFFF_FFFF;
  localparam logic [63:0] NMAX = 64'hFFEF_FFFF_FFFF_FFFF;
  localparam logic [63:0] PINF = 64'h7FF0_0000_0000_0000;
  localparam logic [63:0] NINF = 64'hFFF0_0000_0000_0000;

  task automatic check(input bit ok, input string what, input logic [MAXVL-1:0] act, input logic [MAXVL-1:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", what, act, expv);
    end
  endtask

  task automatic final_report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  function automatic logic [MAXVL-1:0] rand_vec();
    logic [MAXVL-1:0] v;
    for (int i = 0; i < MAXVL/32; i++) v[i*32 +: 32] = $urandom();
    return v;
  endfunction

  function automatic logic [63:0] step_up(input logic [63:0] x);
    if (!x[63]) return x + 64'd1;
    if (x == 64'h8000_0000_0000_0000) return 64'd1;
    return x - 64'd1;
  endfunction

  function automatic logic [63:0] step_dn(input logic [63:0] x);
    if (x[63]) return x + 64'd1;
    if (x == 64'd0) return 64'h8000_0000_0000_0001;
    return x - 64'd1;
  endfunction

  // reference built from the requirement text; flags [0]inv [1]den [2]ovf [3]unf [4]inx
  task automatic ref_add(input logic [63:0] a, input logic [63:0] b, input logic [1:0] rm,
                         output logic [63:0] r, output logic [4:0] f);
    bit  an, bn, asn, bsn, ai, bi, ti;
    real ra, rb, s, bv, err;
    logic [63:0] sbits;
    an  = (a[62:52] == 11'h7FF) && (a[51:0] != 0);
    bn  = (b[62:52] == 11'h7FF) && (b[51:0] != 0);
    asn = an && !a[51];
    bsn = bn && !b[51];
    ai  = (a[62:52] == 11'h7FF) && (a[51:0] == 0);
    bi  = (b[62:52] == 11'h7FF) && (b[51:0] == 0);
    f = 5'd0;
    f[1] = ((a[62:52] == 0) && (a[51:0] != 0)) || ((b[62:52] == 0) && (b[51:0] != 0));
    if (an || bn) begin
      f[0] = asn || bsn;
      r = an ? (a | 64'h0008_0000_0000_0000) : (b | 64'h0008_0000_0000_0000);
    end else if (ai && bi && (a[63] != b[63])) begin
      f[0] = 1'b1;
      r = 64'hFFF8_0000_0000_0000;
    end else if (ai) r = a;
    else if (bi) r = b;
    else begin
      ra = $bitstoreal(a);
      rb = $bitstoreal(b);
      s  = ra + rb;
      sbits = $realtobits(s);
      if (sbits[62:52] == 11'h7FF) begin
        ti = (rm == 2'b00) || (rm == 2'b10 && !sbits[63]) || (rm == 2'b01 && sbits[63]);
        r = ti ? {sbits[63], 11'h7FF, 52'd0} : {sbits[63], 11'h7FE, {52{1'b1}}};
        f[2] = 1'b1;
        f[4] = 1'b1;
      end else begin
        bv  = s - ra;
        err = (ra - (s - bv)) + (rb - bv);
        r = sbits;
        if (s == 0.0 && err == 0.0) begin
          if (a[63] != b[63]) r = {(rm == 2'b01), 63'd0};
        end else if (err != 0.0) begin
          f[4] = 1'b1;
          case (rm)
            2'b01: if (err < 0.0) r = step_dn(r);
            2'b10: if (err > 0.0) r = step_up(r);
            2'b11: if ((err < 0.0) != r[63]) r = r - 64'd1;
            default: ;
          endcase
          if (r[62:52] == 11'h7FF) f[2] = 1'b1;
        end
        f[3] = (r[62:52] == 0) && f[4];
      end
    end
  endtask

  task automatic drive(input logic [1:0] fm, input logic [63:0] alo, input logic [63:0] blo,
                       input logic [63:0] olo, input bit p_use, input bit p_bit, input bit z,
                       input bit e_en, input logic [1:0] e_rm, input bit reg2,
                       input logic [1:0] g_rm, input string tag);
    logic [1:0]       rm;
    logic [63:0]      a, sv;
    logic [4:0]       f;
    bit               wr;
    exp_t             e;
    logic [MAXVL-1:0] s1, s2, od;
    s1 = rand_vec(); s2 = rand_vec(); od = rand_vec();
    s1[63:0] = alo; s2[63:0] = blo; od[63:0] = olo;
    rm = (e_en && reg2) ? e_rm : g_rm;
    a  = (fm == 2'b00) ? olo : alo;
    ref_add(a, blo, rm, sv, f);
    wr = (fm != 2'b10) || !p_use || p_bit;
    if (!wr) f = 5'd0;
    e.dv = '0;
    e.dv[63:0] = wr ? sv : (z ? 64'd0 : olo);
    if (fm == 2'b00) e.dv[MAXVL-1:64] = od[MAXVL-1:64];
    else             e.dv[127:64] = s1[127:64];
    e.fv = f;
    e.tag = tag;
    sb_q.push_back(e);
    in_valid = 1'b1; form = fm; src1 = s1; src2 = s2; dold = od;
    pu = p_use; pb = p_bit; zs = z; oen = e_en; orm = e_rm; isreg = reg2; grm = g_rm;
    @(negedge clk);
  endtask

  function automatic logic [63:0] rnd_fp(input logic [10:0] near_e, input bit use_near);
    logic [63:0] t;
    logic [10:0] ex;
    t = {$urandom(), $urandom()};
    if ($urandom_range(0, 7) == 0) ex = 11'd0;
    else if (use_near)             ex = near_e + 11'($urandom_range(0, 3));
    else                           ex = 11'($urandom_range(1, 2000));
    return {t[63], ex, t[51:0]};
  endfunction

  always @(posedge clk) v_d <= in_valid;

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      check(out_valid == v_d, "R1 valid latency", {255'd0, out_valid}, {255'd0, v_d});
      if (out_valid) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R1 unexpected result", dest, '0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          sticky_exp = sticky_exp | e.fv;
          last_dest = e.dv;
          check(dest == e.dv, {e.tag, " dest"}, dest, e.dv);
          check(flags == e.fv, {e.tag, " R11 flags"}, {251'd0, flags}, {251'd0, e.fv});
          check(sticky == sticky_exp, {e.tag, " R12 sticky"}, {251'd0, sticky}, {251'd0, sticky_exp});
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R1 watchdog expired", '0, '1);
    final_report();
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; form = 2'b00; src1 = '0; src2 = '0; dold = '0;
    pu = 1'b0; pb = 1'b0; zs = 1'b0; oen = 1'b0; orm = 2'b00; isreg = 1'b0; grm = 2'b00;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    check(out_valid == 1'b0, "R12 reset valid", {255'd0, out_valid}, '0);
    check(dest == '0, "R12 reset dest", dest, '0);
    check({flags, sticky} == 10'd0, "R12 reset flags", {246'd0, flags, sticky}, '0);

    // R2 rounding of a tie and of directed modes
    drive(2'b01, ONE, H53, 64'd0, 0, 0, 0, 0, 2'b00, 1, 2'b00, "R2 tie nearest");
    drive(2'b01, ONE, H53, 64'd0, 0, 0, 0, 0, 2'b00, 1, 2'b10, "R2 tie up");
    drive(2'b01, MONE, 64'hBCA0_0000_0000_0000, 64'd0, 0, 0, 0, 0, 2'b00, 1, 2'b01, "R2 tie down");
    drive(2'b01, ONE, 64'hBC90_0000_0000_0000, 64'd0, 0, 0, 0, 0, 2'b00, 1, 2'b11, "R2 toward zero");
    // R3 rounding source selection
    drive(2'b01, ONE, H53, 64'd0, 0, 0, 0, 1, 2'b10, 1, 2'b00, "R3 override used");
    drive(2'b01, ONE, H53, 64'd0, 0, 0, 0, 1, 2'b10, 0, 2'b00, "R3 memory source");
    drive(2'b01, ONE, H53, 64'd0, 0, 0, 0, 0, 2'b10, 1, 2'b00, "R3 override off");
    // R7 NaN cases
    drive(2'b01, 64'h7FF0_0000_0000_0001, ONE, 64'd0, 0, 0, 0, 0, 2'b00, 1, 2'b00, "R7 snan src1");
    drive(2'b01, 64'h7FF8_0000_0000_0002, 64'hFFF0_0000_0000_0003, 64'd0, 0, 0, 0, 0, 2'b00, 1, 2'b00, "R7 both nan");
    drive(2'b01, ONE, 64'h7FF8_0000_0000_0005, 64'd0, 0, 0, 0, 0, 2'b00, 1, 2'b00, "R7 qnan src2");
    // R8 infinities
    drive(2'b01, PINF, NINF, 64'd0, 0, 0, 0, 0, 2'b00, 1, 2'b00, "R8 inf minus inf");
    drive(2'b01, PINF, ONE, 64'd0, 0, 0, 0, 0, 2'b00, 1, 2'b00, "R8 inf plus one");
    // R9 exact zero signs
    drive(2'b01, ONE, MONE, 64'd0, 0, 0, 0, 0, 2'b00, 1, 2'b00, "R9 zero nearest");
    drive(2'b01, ONE, MONE, 64'd0, 0, 0, 0, 0, 2'b00, 1, 2'b01, "R9 zero down");
    drive(2'b01, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 64'd0, 0, 0, 0, 0, 2'b00, 1, 2'b00, "R9 neg zeros");
    // R10 overflow per mode
    for (int m = 0; m < 4; m++) begin
      drive(2'b01, MAXF, MAXF, 64'd0, 0, 0, 0, 0, 2'b00, 1, 2'(m), "R10 pos overflow");
      drive(2'b01, NMAX, NMAX, 64'd0, 0, 0, 0, 0, 2'b00, 1, 2'(m), "R10 neg overflow");
    end
    drive(2'b01, MAXF, 64'h7CA0_0000_0000_0000, 64'd0, 0, 0, 0, 0, 2'b00, 1, 2'b10, "R10 step to inf");
    // R11 subnormal operands
    drive(2'b01, 64'd3, 64'd5, 64'd0, 0, 0, 0, 0, 2'b00, 1, 2'b00, "R11 subnormal sum");
    drive(2'b01, 64'h0010_0000_0000_0000, 64'h8000_0000_0000_0001, 64'd0, 0, 0, 0, 0, 2'b00, 1, 2'b00, "R11 min normal cancel");
    // R4 two-operand form ignores src1 low lane
    drive(2'b00, 64'h4010_0000_0000_0000, TWO, 64'h3FF8_0000_0000_0000, 0, 0, 0, 0, 2'b00, 1, 2'b00, "R4 two operand");
    // R5 alternate three-operand code
    drive(2'b11, ONE, TWO, 64'd0, 0, 0, 0, 0, 2'b00, 1, 2'b00, "R5 form 11");
    // R6 predication
    drive(2'b10, MAXF, MAXF, 64'h1234_5678_9ABC_DEF0, 1, 0, 0, 0, 2'b00, 1, 2'b00, "R6 merge suppressed");
    drive(2'b10, MAXF, MAXF, 64'h1234_5678_9ABC_DEF0, 1, 0, 1, 0, 2'b00, 1, 2'b00, "R6 zero suppressed");
    drive(2'b10, ONE, TWO, 64'h1234_5678_9ABC_DEF0, 1, 1, 1, 0, 2'b00, 1, 2'b00, "R6 predicate set");
    drive(2'b10, ONE, TWO, 64'h1234_5678_9ABC_DEF0, 0, 0, 1, 0, 2'b00, 1, 2'b00, "R6 predicate unused");

    // random sweep over forms, modes and operand classes
    for (int k = 0; k < 600; k++) begin
      logic [63:0] ea, eb, ol;
      logic [1:0]  fm;
      ea = rnd_fp(11'd0, 1'b0);
      eb = rnd_fp(ea[62:52], $urandom_range(0, 1) == 1);
      fm = 2'($urandom_range(0, 3));
      ol = (fm == 2'b00) ? ea : {$urandom(), $urandom()};
      drive(fm, ea, eb, ol, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
            $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, 2'($urandom_range(0, 3)),
            $urandom_range(0, 1) == 1, 2'($urandom_range(0, 3)), "R2 random");
      if ((k % 37) == 5) begin
        in_valid = 1'b0;
        src1 = rand_vec(); dold = rand_vec();
        @(negedge clk);
      end
    end

    in_valid = 1'b0;
    src1 = rand_vec(); src2 = rand_vec(); dold = rand_vec();
    repeat (4) @(negedge clk);
    check(sb_q.size() == 0, "R1 all results seen", {224'd0, 32'(sb_q.size())}, '0);
    check(dest == last_dest, "R1 hold when idle", dest, last_dest);
    final_report();
  end

endmodule